// File: doc/BRIEF.md
# Cascadable Presettable Decade/Binary Counter

This block is a synchronous up-counter whose width follows from its modulus. A parameter sets it to count 0..9 (decade) or 0..15 (binary). A second parameter decides how the active-low clear acts. It can act at once, without waiting for a clock. Or it can wait for the next rising edge and then take precedence over everything else. An active-low load copies the data inputs into the counter on a rising edge.

Counting needs two enables. The first, `en_p`, is a plain parallel enable. The second, `en_t`, is a trickle enable that also gates the terminal-count output.

To build a wider counter, connect `tc` of one stage to `en_t` of the next stage. Share the clock and `en_p` across all stages. Every stage then advances on the same edge, and a higher digit steps only when all lower digits sit at their maximum.

Top module: `sync_cascade_counter`

## Requirements
- R1: Under counting, the value advances by one per rising edge. From the maximum (9 when MODULUS=10, 15 when MODULUS=16) it returns to 0.
- R2: With ASYNC_CLEAR=1, a low `clr_n` forces `q` to 0 at once, without a clock edge, and overrides every other input.
- R3: With ASYNC_CLEAR=0, a low `clr_n` leaves `q` untouched between edges. At the next rising edge it sets `q` to 0, even when `load_n` is low or both enables are high.
- R4: With `clr_n` high and `load_n` low at a rising edge, `q` takes `din`. This happens whatever the two enables are.
- R5: With `clr_n` and `load_n` high, `q` holds its value across an edge unless `en_p` and `en_t` are both 1.
- R6: `tc` is 1 exactly when `en_t` is 1 and `q` equals the maximum. `en_p` and `load_n` have no effect on `tc`.
- R7: When MODULUS=10, a loaded value from 10 to 14 steps to the next binary value when counted. A loaded 15 steps to 0, so the counter never locks up.
- R8: When two stages are chained through `tc` into `en_t`, they count 00..99 in decade mode. The upper stage steps only on the edge where the lower stage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; timing set by ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | W | Value loaded when `load_n` is low |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates `tc` |
| q | output | W | Current count |
| tc | output | 1 | Terminal count, high at maximum with `en_t` high |

## Verification
Clear, load and count can all be requested on the same edge. The bench therefore forces these collisions on purpose. It drives a low clear together with a low load and both enables high, and it drives a load together with both enables high. It then checks that only the higher-priority action is visible in `q` after the edge.

A further probe lowers the clear half a cycle before an edge. At that instant the decade pair must already read zero, while the synchronous-clear binary instance must still show its previous value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op,
  output logic    upd
);
  // load beats count; clear is handled in the register stage
  always_comb begin
    if (!load_n)           op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
    upd = (op != OP_HOLD);
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int MODULUS = 10,
  parameter int W       = 4
) (
  input  cnt_op_e      op,
  input  logic [W-1:0] q,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] MAX_V = W'(MODULUS - 1);

  logic [W-1:0] inc;

  // a value above MAX_V keeps stepping in plain binary and wraps at 2**W
  always_comb begin
    inc = (q == MAX_V) ? '0 : q + W'(1);
    unique case (op)
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = inc;
      default:  nxt = q;
    endcase
  end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int MODULUS = 10,
  parameter int W       = 4
) (
  input  logic [W-1:0] q,
  input  logic         en_t,
  output logic         tc
);
  localparam logic [W-1:0] MAX_V = W'(MODULUS - 1);

  always_comb tc = en_t && (q == MAX_V);
endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int W           = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         upd,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)   q <= '0;
        else if (upd) q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n)   q <= '0;
        else if (upd) q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/sync_cascade_counter.sv
module sync_cascade_counter
  import cnt_pkg::*;
#(
  parameter int MODULUS     = 10,
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter int W           = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         tc
);
  cnt_op_e      op;
  logic         upd;
  logic [W-1:0] nxt;

  cnt_ctrl u_ctrl (
    .load_n(load_n), .en_p(en_p), .en_t(en_t), .op(op), .upd(upd)
  );

  cnt_next #(.MODULUS(MODULUS), .W(W)) u_next (
    .op(op), .q(q), .din(din), .nxt(nxt)
  );

  cnt_reg #(.W(W), .ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
    .clk(clk), .clr_n(clr_n), .upd(upd), .nxt(nxt), .q(q)
  );

  cnt_tc #(.MODULUS(MODULUS), .W(W)) u_tc (
    .q(q), .en_t(en_t), .tc(tc)
  );
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int MODULUS     = 10,
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter int W           = 4
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic [W-1:0] din,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] q,
  input logic         tc
);
  localparam logic [W-1:0] MAX_V = W'(MODULUS - 1);

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && en_p && en_t && q == MAX_V |=> q == '0);

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && en_p && en_t && q != MAX_V |=> q == $past(q) + W'(1));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && !(en_p && en_t) |=> $stable(q));

  // R6
  tc_gate_chk: assert property (@(posedge clk)
    tc |-> en_t && q == MAX_V);

  // R6
  tc_raise_chk: assert property (@(posedge clk)
    en_t && q == MAX_V |-> tc);

  generate
    if (ASYNC_CLEAR) begin : g_ac
      // R2
      async_zero_chk: assert property (@(posedge clk) !clr_n |-> q == '0);
    end else begin : g_sc
      // R3
      sync_zero_chk: assert property (@(posedge clk) !clr_n |=> q == '0);
    end
  endgenerate
endmodule

bind sync_cascade_counter cnt_checker #(
  .MODULUS(MODULUS), .ASYNC_CLEAR(ASYNC_CLEAR), .W(W)
) chk_i (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
  .en_p(en_p), .en_t(en_t), .q(q), .tc(tc)
);

// File: tb/sync_cascade_counter_tb_top.sv
`timescale 1ns/1ps
module sync_cascade_counter_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr_n, load_n, en_p, en_t;
  logic [3:0] d_lo, d_hi, d_b;
  logic [3:0] q_lo, q_hi, q_b;
  logic       tc_lo, tc_hi, tc_b;

  // decade pair, immediate clear, chained through tc
  sync_cascade_counter #(.MODULUS(10), .ASYNC_CLEAR(1'b1)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_lo),
    .en_p(en_p), .en_t(en_t), .q(q_lo), .tc(tc_lo));
  sync_cascade_counter #(.MODULUS(10), .ASYNC_CLEAR(1'b1)) dut_hi_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_hi),
    .en_p(en_p), .en_t(tc_lo), .q(q_hi), .tc(tc_hi));
  // binary, edge-timed clear
  sync_cascade_counter #(.MODULUS(16), .ASYNC_CLEAR(1'b0)) dut_b_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_b),
    .en_p(en_p), .en_t(en_t), .q(q_b), .tc(tc_b));

  typedef struct {
    logic [3:0] lo, hi, b;
    logic       tlo, thi, tb;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] m_lo = 4'd0, m_hi = 4'd0, m_b = 4'd0;

  function automatic logic [3:0] step(input logic [3:0] q, input int m,
      input logic c, input logic l, input logic [3:0] d,
      input logic ep, input logic et);
    if (!c) return 4'd0;
    if (!l) return d;
    if (ep && et) return (q == 4'(m - 1)) ? 4'd0 : q + 4'd1;
    return q;
  endfunction

  task automatic drive(input logic c, input logic l, input logic [3:0] dl,
      input logic [3:0] dh, input logic [3:0] db, input logic ep,
      input logic et, input string tag);
    exp_t e;
    logic tpre;
    @(negedge clk);
    clr_n = c; load_n = l; d_lo = dl; d_hi = dh; d_b = db;
    en_p = ep; en_t = et;
    tpre = et && (m_lo == 4'd9);
    m_lo = step(m_lo, 10, c, l, dl, ep, et);
    m_hi = step(m_hi, 10, c, l, dh, ep, tpre);
    m_b  = step(m_b, 16, c, l, db, ep, et);
    e.lo = m_lo; e.hi = m_hi; e.b = m_b;
    e.tlo = et && (m_lo == 4'd9);
    e.thi = e.tlo && (m_hi == 4'd9);
    e.tb  = et && (m_b == 4'd15);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what,
      input logic [3:0] act, input logic [3:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      bad = 1'b1;
    end
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = 1'b0;
        cmp(e.tag, "q_lo", q_lo, e.lo, bad);
        cmp(e.tag, "q_hi", q_hi, e.hi, bad);
        cmp(e.tag, "q_b", q_b, e.b, bad);
        cmp(e.tag, "tc_lo", {3'd0, tc_lo}, {3'd0, e.tlo}, bad);
        cmp(e.tag, "tc_hi", {3'd0, tc_hi}, {3'd0, e.thi}, bad);
        cmp(e.tag, "tc_b", {3'd0, tc_b}, {3'd0, e.tb}, bad);
        checks++;
        if (bad) errors++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    d_lo = 4'd0; d_hi = 4'd0; d_b = 4'd0;
    #1;
    // R2: reset state before any edge
    checks++;
    if (q_lo !== 4'd0 || q_hi !== 4'd0) begin
      errors++;
      $display("FAIL R2 reset lo %0d hi %0d expected 0", q_lo, q_hi);
    end
    drive(0, 1, 0, 0, 0, 0, 0, "R3 reset");
    // R1 R8: long run, pair wraps 99 -> 00, binary wraps several times
    for (int i = 0; i < 120; i++) drive(1, 1, 0, 0, 0, 1, 1, "R1 R8 count");
    // R4: load with enables low
    drive(1, 0, 9, 3, 15, 0, 0, "R4 load");
    // R5 R6: hold with trickle high, tc must show
    drive(1, 1, 0, 0, 0, 0, 1, "R5 R6 hold ep low");
    drive(1, 1, 0, 0, 0, 0, 1, "R5 R6 hold ep low");
    // R5 R6: trickle low hides tc and holds
    drive(1, 1, 0, 0, 0, 1, 0, "R5 R6 hold et low");
    // R4: load beats count on same edge
    drive(1, 0, 2, 7, 5, 1, 1, "R4 load over count");
    // R3: clear beats load on same edge
    drive(0, 0, 6, 6, 6, 1, 1, "R3 clear over load");
    // R7: out-of-range decade values recover
    drive(1, 0, 12, 10, 14, 0, 0, "R7 load high");
    for (int i = 0; i < 5; i++) drive(1, 1, 0, 0, 0, 1, 1, "R7 recover");
    // R2 R3: clear lowered between edges
    @(negedge clk);
    clr_n = 1'b0; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    #2;
    checks++;
    if (q_lo !== 4'd0 || q_hi !== 4'd0) begin
      errors++;
      $display("FAIL R2 immediate clear lo %0d hi %0d expected 0", q_lo, q_hi);
    end
    checks++;
    if (q_b !== m_b) begin
      errors++;
      $display("FAIL R3 early clear q_b actual %0d expected %0d", q_b, m_b);
    end
    begin
      exp_t e;
      m_lo = 4'd0; m_hi = 4'd0; m_b = 4'd0;
      e.lo = 0; e.hi = 0; e.b = 0; e.tlo = 0; e.thi = 0; e.tb = 0;
      e.tag = "R3 edge clear";
      exp_q.push_back(e);
    end
    for (int i = 0; i < 30; i++) drive(1, 1, 0, 0, 0, 1, 1, "R1 R6 count");
    drive(1, 1, 0, 0, 0, 0, 0, "R5 idle");
    wait (exp_q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule